// File: doc/BRIEF.md
# Mixed-Page-Size Translation Cache

This block is a fully associative cache of address translations that sits beside a load/store or fetch unit. Each entry holds one mapping from a virtual page to a physical frame, with its own page size (4 KB, 2 MB or 1 GB) and its own read, write and execute rights. Because the size is stored per entry, mappings of all three sizes can sit side by side in the same array. The tag compare ignores the virtual page bits that fall inside that entry's page. Those bits then pass straight through into the physical address.

A lookup is presented for one cycle and its result is registered, so it appears on the next cycle. A result is one of three things: a hit with the physical address and rights, a protection fault, or a miss. A miss also raises a request, with the missed address, toward an external table walker. The walker later writes its answer through a fill port. A fill goes into the lowest-numbered free slot if there is one, and otherwise into the slot named by a rotating pointer. Software or control logic can drop every entry at once, or only the entries that cover a given address.

Top module: `tlb_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rsp_valid`, `rsp_hit`, `rsp_fault` and `walk_req` are low. Every entry starts invalid, so the first lookup after reset misses.
- R2: A lookup accepted on a clock edge gives its result on the outputs after that same edge. On a hit, `rsp_paddr` is the stored frame followed by virtual address bits 11:0, and `rsp_perm` is the stored rights.
- R3: A lookup that matches no valid entry gives `rsp_valid`=1, `rsp_hit`=0 and `rsp_fault`=0. In the same cycle it raises `walk_req` with `walk_vaddr` equal to the looked-up address.
- R4: The page size code is 0 for 4 KB, 1 for 2 MB, 2 for 1 GB, and 3 is treated as 4 KB. The compare skips virtual bits 20:12 for 2 MB and bits 29:12 for 1 GB. Physical address bits 20:12 or 29:12 are then taken from the virtual address.
- R5: The rights bits are bit 0 read, bit 1 write and bit 2 execute. The access code is 0 read, 1 write, 2 execute, and 3 is treated as read. A matching entry that lacks the needed right gives `rsp_fault`=1 and `rsp_hit`=0, with no walk request.
- R6: A fill writes the lowest-numbered invalid entry when one exists, and the rotating pointer does not move. When every entry is valid, the fill writes the entry the pointer names, and the pointer then steps by one and wraps to 0 after the last entry.
- R7: Invalidate-by-address clears every valid entry whose tag, masked by that entry's own page size, matches the given address. All other entries are left as they were.
- R8: Invalidate-all clears every entry in one cycle. A lookup in the next cycle misses.
- R9: A lookup sees the array as it stood before any fill or invalidation in the same cycle.
- R10: When a fill and an invalidation fall in the same cycle, the invalidation is applied first and the filled entry stays valid. The victim slot is chosen from the valid bits as they were before the invalidation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 48 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| fill_valid | input | 1 | Write a new translation |
| fill_vaddr | input | 48 | Virtual address of the new page |
| fill_pfn | input | 28 | Physical frame of the new page |
| fill_size | input | 2 | Page size code of the new page |
| fill_perm | input | 3 | Rights of the new page (bit 0 R, bit 1 W, bit 2 X) |
| inv_all | input | 1 | Clear every entry |
| inv_addr_valid | input | 1 | Clear the entries covering `inv_vaddr` |
| inv_vaddr | input | 48 | Address for selective invalidation |
| rsp_valid | output | 1 | A lookup result is present |
| rsp_hit | output | 1 | Translation found and allowed |
| rsp_fault | output | 1 | Translation found but the access is not allowed |
| rsp_paddr | output | 40 | Translated physical address (valid on hit) |
| rsp_perm | output | 3 | Rights of the hit entry |
| walk_req | output | 1 | Miss, a table walk is needed |
| walk_vaddr | output | 48 | Address that missed |

## Verification
Two pairs of operations can share a cycle. A lookup can arrive together with the fill that would satisfy it. A fill can also arrive together with an invalidate-all or an invalidate-by-address. The bench drives both pairs on purpose. It expects the lookup to miss and the next identical lookup to hit, and it expects the new entry to outlive the invalidation that shared its cycle. A behavioural model checks every cycle, and it applies the same ordering: the lookup reads the old array, the victim is chosen from the old valid bits, the invalidation is applied, and the fill is written last.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W  = 48;
    localparam int PA_W  = 40;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PFN_W = PA_W - OFF_W;
    localparam int MID_W = 9;   // page-number bits inside a 2 MB page
    localparam int BIG_W = 18;  // page-number bits inside a 1 GB page

    typedef enum logic [1:0] {PG_4K = 2'd0, PG_2M = 2'd1, PG_1G = 2'd2, PG_RSV = 2'd3} pg_size_e;
    typedef enum logic [1:0] {ACC_RD = 2'd0, ACC_WR = 2'd1, ACC_EX = 2'd2, ACC_ALT = 2'd3} acc_e;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        pg_size_e         size;
        logic [2:0]       perm;
    } tlb_ent_t;

    // Page-number bits that take part in the tag compare
    function automatic logic [VPN_W-1:0] pg_mask(input pg_size_e s);
        logic [VPN_W-1:0] m;
        m = '1;
        if (s == PG_2M) m[MID_W-1:0] = '0;
        else if (s == PG_1G) m[BIG_W-1:0] = '0;
        return m;
    endfunction

    function automatic logic [PA_W-1:0] make_pa(input logic [PFN_W-1:0] pfn,
                                                 input pg_size_e s,
                                                 input logic [VA_W-1:0] va);
        logic [PA_W-1:0] pa;
        pa = {pfn, va[OFF_W-1:0]};
        if (s == PG_2M) pa[OFF_W+MID_W-1:OFF_W] = va[OFF_W+MID_W-1:OFF_W];
        else if (s == PG_1G) pa[OFF_W+BIG_W-1:OFF_W] = va[OFF_W+BIG_W-1:OFF_W];
        return pa;
    endfunction

    function automatic logic [2:0] need_mask(input acc_e a);
        case (a)
            ACC_WR:  return 3'b010;
            ACC_EX:  return 3'b100;
            default: return 3'b001;
        endcase
    endfunction
endpackage

// File: rtl/tlb_first.sv
module tlb_first #(
    parameter int N  = 64,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic     [ENTRIES-1:0] vld,
    input  tlb_ent_t [ENTRIES-1:0] ent,
    input  logic     [VA_W-1:0]    vaddr,
    output logic     [ENTRIES-1:0] match
);
    logic [VPN_W-1:0] vpn;
    assign vpn = vaddr[VA_W-1:OFF_W];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld[g] &&
            (((ent[g].vpn ^ vpn) & pg_mask(ent[g].size)) == '0);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 64,
    parameter int IW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] vld,
    input  logic [IW-1:0]      rr_ptr,
    output logic [IW-1:0]      vic_idx,
    output logic               use_rr
);
    logic          free_any;
    logic [IW-1:0] free_idx;

    tlb_first #(.N(ENTRIES), .IW(IW)) u_free (
        .req (~vld),
        .any (free_any),
        .idx (free_idx)
    );

    assign use_rr  = !free_any;
    assign vic_idx = free_any ? free_idx : rr_ptr;
endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_acc,
    input  logic             fill_valid,
    input  logic [VA_W-1:0]  fill_vaddr,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [1:0]       fill_size,
    input  logic [2:0]       fill_perm,
    input  logic             inv_all,
    input  logic             inv_addr_valid,
    input  logic [VA_W-1:0]  inv_vaddr,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [2:0]       rsp_perm,
    output logic             walk_req,
    output logic [VA_W-1:0]  walk_vaddr
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic     [ENTRIES-1:0] vld;
        tlb_ent_t [ENTRIES-1:0] ent;
        logic     [IW-1:0]      rr;
        logic                   rv;
        logic                   rh;
        logic                   rf;
        logic     [PA_W-1:0]    pa;
        logic     [2:0]         perm;
        logic                   wreq;
        logic     [VA_W-1:0]    wva;
    } st_t;

    st_t st_q, st_d;

    logic [ENTRIES-1:0] lk_match, inv_match;
    logic               lk_any;
    logic [IW-1:0]      lk_idx;
    logic [IW-1:0]      vic_idx;
    logic               vic_rr;

    tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .vld   (st_q.vld),
        .ent   (st_q.ent),
        .vaddr (lk_vaddr),
        .match (lk_match)
    );

    tlb_match #(.ENTRIES(ENTRIES)) u_inv_match (
        .vld   (st_q.vld),
        .ent   (st_q.ent),
        .vaddr (inv_vaddr),
        .match (inv_match)
    );

    tlb_first #(.N(ENTRIES), .IW(IW)) u_hit_sel (
        .req (lk_match),
        .any (lk_any),
        .idx (lk_idx)
    );

    tlb_victim #(.ENTRIES(ENTRIES), .IW(IW)) u_victim (
        .vld     (st_q.vld),
        .rr_ptr  (st_q.rr),
        .vic_idx (vic_idx),
        .use_rr  (vic_rr)
    );

    always_comb begin
        tlb_ent_t e;
        logic     allowed;
        st_d      = st_q;
        st_d.rv   = lk_valid;
        st_d.rh   = 1'b0;
        st_d.rf   = 1'b0;
        st_d.wreq = 1'b0;
        st_d.pa   = '0;
        st_d.perm = '0;
        e         = st_q.ent[lk_idx];
        allowed   = |(e.perm & need_mask(acc_e'(lk_acc)));

        // Lookup reads the array as registered
        if (lk_valid) begin
            if (lk_any) begin
                st_d.rh   = allowed;
                st_d.rf   = !allowed;
                st_d.pa   = make_pa(e.pfn, e.size, lk_vaddr);
                st_d.perm = e.perm;
            end else begin
                st_d.wreq = 1'b1;
                st_d.wva  = lk_vaddr;
            end
        end

        // Invalidation first, then fill
        if (inv_all) begin
            st_d.vld = '0;
        end else if (inv_addr_valid) begin
            st_d.vld = st_q.vld & ~inv_match;
        end

        if (fill_valid) begin
            st_d.vld[vic_idx]      = 1'b1;
            st_d.ent[vic_idx].vpn  = fill_vaddr[VA_W-1:OFF_W];
            st_d.ent[vic_idx].pfn  = fill_pfn;
            st_d.ent[vic_idx].size = pg_size_e'(fill_size);
            st_d.ent[vic_idx].perm = fill_perm;
            if (vic_rr) begin
                st_d.rr = (st_q.rr == IW'(ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid  = st_q.rv;
    assign rsp_hit    = st_q.rh;
    assign rsp_fault  = st_q.rf;
    assign rsp_paddr  = st_q.pa;
    assign rsp_perm   = st_q.perm;
    assign walk_req   = st_q.wreq;
    assign walk_vaddr = st_q.wva;
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
    import tlb_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            fill_valid,
    input logic            inv_all,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            walk_req,
    input logic [VA_W-1:0] walk_vaddr
);
    // R5
    hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_fault));

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R2
    rsp_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(lk_valid));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]));

    // R3
    walk_only_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> (rsp_valid && !rsp_hit && !rsp_fault));

    // R3
    walk_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> walk_vaddr == $past(lk_vaddr));

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(inv_all, 2) && !$past(fill_valid, 2)) |-> (!rsp_hit && !rsp_fault));
endmodule

bind tlb_top tlb_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_vaddr   (lk_vaddr),
    .fill_valid (fill_valid),
    .inv_all    (inv_all),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_fault  (rsp_fault),
    .rsp_paddr  (rsp_paddr),
    .walk_req   (walk_req),
    .walk_vaddr (walk_vaddr)
);

// File: tb/tlb_top_tb.sv
module tlb_top_tb;
    localparam int ENT = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_vaddr = '0;
    logic [1:0]  lk_acc = '0;
    logic        fill_valid = 1'b0;
    logic [47:0] fill_vaddr = '0;
    logic [27:0] fill_pfn = '0;
    logic [1:0]  fill_size = '0;
    logic [2:0]  fill_perm = '0;
    logic        inv_all = 1'b0;
    logic        inv_addr_valid = 1'b0;
    logic [47:0] inv_vaddr = '0;
    logic        rsp_valid, rsp_hit, rsp_fault, walk_req;
    logic [39:0] rsp_paddr;
    logic [2:0]  rsp_perm;
    logic [47:0] walk_vaddr;

    always #5 clk = ~clk;

    tlb_top #(.ENTRIES(ENT)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc),
        .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_pfn(fill_pfn),
        .fill_size(fill_size), .fill_perm(fill_perm),
        .inv_all(inv_all), .inv_addr_valid(inv_addr_valid), .inv_vaddr(inv_vaddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
        .walk_req(walk_req), .walk_vaddr(walk_vaddr)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_vld [ENT];
    logic [35:0] m_vpn [ENT];
    logic [27:0] m_pfn [ENT];
    logic [1:0]  m_size[ENT];
    logic [2:0]  m_perm[ENT];
    int          m_ptr;

    bit          e_v, e_h, e_f, e_w;
    logic [39:0] e_pa;
    logic [2:0]  e_perm;
    logic [47:0] e_wva;
    string       e_tag;

    function automatic logic [35:0] keep_bits(input logic [1:0] s);
        logic [35:0] m = '1;
        if (s == 2'd1) m[8:0] = '0;
        else if (s == 2'd2) m[17:0] = '0;
        return m;
    endfunction

    function automatic int find_entry(input logic [47:0] va);
        for (int i = 0; i < ENT; i++)
            if (m_vld[i] && (((m_vpn[i] ^ va[47:12]) & keep_bits(m_size[i])) == '0))
                return i;
        return -1;
    endfunction

    function automatic logic [39:0] phys(input int i, input logic [47:0] va);
        logic [39:0] base, low;
        base = {m_pfn[i], 12'h000};
        low  = {28'h0, va[11:0]};
        if (m_size[i] == 2'd1) low = {19'h0, va[20:0]};
        else if (m_size[i] == 2'd2) low = {10'h0, va[29:0]};
        base = base & ~({40{1'b1}} >> (40 - ((m_size[i] == 2'd1) ? 21 : (m_size[i] == 2'd2) ? 30 : 12)));
        return base | low;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENT; i++) m_vld[i] = 0;
            m_ptr = 0;
            e_v = 0; e_h = 0; e_f = 0; e_w = 0; e_pa = '0; e_perm = '0; e_tag = "R1";
        end else begin
            int hit_i, vic;
            bit need, used_ptr;
            e_v = lk_valid; e_h = 0; e_f = 0; e_w = 0; e_pa = '0; e_perm = '0; e_tag = "R2";
            if (lk_valid) begin
                hit_i = find_entry(lk_vaddr);
                if (hit_i >= 0) begin
                    need = (lk_acc == 2'd1) ? m_perm[hit_i][1] :
                           (lk_acc == 2'd2) ? m_perm[hit_i][2] : m_perm[hit_i][0];
                    e_h = need; e_f = !need;
                    e_pa = phys(hit_i, lk_vaddr); e_perm = m_perm[hit_i];
                    e_tag = need ? "R2" : "R5";
                end else begin
                    e_w = 1; e_wva = lk_vaddr; e_tag = "R3";
                end
            end
            vic = -1;
            for (int i = ENT - 1; i >= 0; i--) if (!m_vld[i]) vic = i;
            used_ptr = (vic < 0);
            if (used_ptr) vic = m_ptr;
            if (inv_all) begin
                for (int i = 0; i < ENT; i++) m_vld[i] = 0;
            end else if (inv_addr_valid) begin
                for (int i = 0; i < ENT; i++)
                    if (m_vld[i] && (((m_vpn[i] ^ inv_vaddr[47:12]) & keep_bits(m_size[i])) == '0))
                        m_vld[i] = 0;
            end
            if (fill_valid) begin
                m_vld[vic] = 1; m_vpn[vic] = fill_vaddr[47:12]; m_pfn[vic] = fill_pfn;
                m_size[vic] = fill_size; m_perm[vic] = fill_perm;
                if (used_ptr) m_ptr = (m_ptr + 1) % ENT;
            end
        end
        #2;
        check({e_tag, " valid"}, 64'(rsp_valid), 64'(e_v));
        check({e_tag, " hit"},   64'(rsp_hit),   64'(e_h));
        check({e_tag, " fault"}, 64'(rsp_fault), 64'(e_f));
        check({e_tag, " walk"},  64'(walk_req),  64'(e_w));
        if (e_h) begin
            check("R4 model paddr", 64'(rsp_paddr), 64'(e_pa));
            check("R5 model perm",  64'(rsp_perm),  64'(e_perm));
        end
        if (e_w) check("R3 model walk addr", 64'(walk_vaddr), 64'(e_wva));
    end

    // ---------------- directed stimulus ----------------
    task automatic tick();
        @(posedge clk);
        #1;
        lk_valid = 0; fill_valid = 0; inv_all = 0; inv_addr_valid = 0;
    endtask

    task automatic put_fill(input logic [47:0] va, input logic [27:0] pfn,
                            input logic [1:0] sz, input logic [2:0] pm);
        fill_valid = 1; fill_vaddr = va; fill_pfn = pfn; fill_size = sz; fill_perm = pm;
    endtask

    task automatic do_fill(input logic [47:0] va, input logic [27:0] pfn,
                           input logic [1:0] sz, input logic [2:0] pm);
        @(negedge clk);
        put_fill(va, pfn, sz, pm);
        tick();
    endtask

    // kind: 0 miss, 1 hit, 2 fault
    task automatic look(input logic [47:0] va, input logic [1:0] acc, input int kind,
                        input logic [39:0] pa, input string tag);
        @(negedge clk);
        lk_valid = 1; lk_vaddr = va; lk_acc = acc;
        tick();
        check({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        check({tag, " rsp_hit"},   64'(rsp_hit),   64'(kind == 1));
        check({tag, " rsp_fault"}, 64'(rsp_fault), 64'(kind == 2));
        check({tag, " walk_req"},  64'(walk_req),  64'(kind == 0));
        if (kind == 1) check({tag, " paddr"}, 64'(rsp_paddr), 64'(pa));
        if (kind == 0) check({tag, " walk_vaddr"}, 64'(walk_vaddr), 64'(va));
    endtask

    localparam logic [47:0] VA_A = 48'h0000_1234_5000;
    localparam logic [47:0] VA_B = 48'h0000_4020_0000;
    localparam logic [47:0] VA_C = 48'h00C0_0000_0000;
    localparam logic [47:0] VA_R = 48'h1000_0000_0000;

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 reset walk_req",  64'(walk_req),  64'd0);
        @(negedge clk);
        rst_n = 1;
        look(VA_A, 2'd0, 0, '0, "R1 empty after reset");

        // 4 KB entry, rights read+write
        do_fill(VA_A, 28'h00ABCDE, 2'd0, 3'b011);
        look(VA_A | 48'h678, 2'd0, 1, 40'h00ABCDE678, "R2 4K read hit");
        look(VA_A | 48'h678, 2'd1, 1, 40'h00ABCDE678, "R5 4K write allowed");
        look(VA_A, 2'd2, 2, '0, "R5 4K exec fault");
        look(VA_A, 2'd3, 1, 40'h00ABCDE000, "R5 code 3 reads");
        look(VA_A + 48'h1000, 2'd0, 0, '0, "R3 neighbour page miss");

        // 2 MB entry
        do_fill(VA_B, 28'h0123400, 2'd1, 3'b101);
        look(48'h0000_402A_B123, 2'd2, 1, 40'h01234AB123, "R4 2M hit low bits pass");
        look(48'h0000_4060_0000, 2'd0, 0, '0, "R4 2M outside miss");

        // 1 GB entry
        do_fill(VA_C, 28'h0AC0000, 2'd2, 3'b111);
        look(48'h00C0_2345_6789, 2'd1, 1, 40'h0AE3456789, "R4 1G hit");
        look(48'h00C0_4000_0000, 2'd0, 0, '0, "R4 1G outside miss");

        // selective invalidate inside the 2 MB page
        @(negedge clk);
        inv_addr_valid = 1; inv_vaddr = 48'h0000_403F_F000;
        tick();
        look(VA_B, 2'd0, 0, '0, "R7 covered entry gone");
        look(VA_A, 2'd0, 1, 40'h00ABCDE000, "R7 other entry kept");
        look(VA_C, 2'd0, 1, 40'h0AC0000000, "R7 1G entry kept");

        // lookup and fill in the same cycle
        @(negedge clk);
        lk_valid = 1; lk_vaddr = 48'h0000_7777_7ABC; lk_acc = 2'd0;
        put_fill(48'h0000_7777_7000, 28'h0000777, 2'd0, 3'b001);
        tick();
        check("R9 same-cycle lookup misses", 64'(walk_req), 64'd1);
        look(48'h0000_7777_7ABC, 2'd0, 1, 40'h0000777ABC, "R9 next lookup hits");

        // flush all
        @(negedge clk);
        inv_all = 1;
        tick();
        look(VA_A, 2'd0, 0, '0, "R8 flush clears 4K");
        look(48'h00C0_2345_6789, 2'd0, 0, '0, "R8 flush clears 1G");

        // flush with fill in the same cycle
        @(negedge clk);
        inv_all = 1;
        put_fill(48'h0000_0000_9000, 28'h0000099, 2'd0, 3'b001);
        tick();
        look(48'h0000_0000_9000, 2'd0, 1, 40'h0000099000, "R10 fill survives flush");

        // replacement order
        @(negedge clk);
        inv_all = 1;
        tick();
        for (int i = 0; i < ENT; i++)
            do_fill(VA_R | (48'(i) << 12), 28'(i + 1), 2'd0, 3'b001);
        do_fill(48'h2000_0000_0000, 28'h0000F00, 2'd0, 3'b001);
        look(VA_R, 2'd0, 0, '0, "R6 pointer slot 0 replaced");
        look(VA_R | 48'h1000, 2'd0, 1, 40'h0000002000, "R6 slot 1 kept");
        look(48'h2000_0000_0000, 2'd0, 1, 40'h0000F00000, "R6 new entry present");
        @(negedge clk);
        inv_addr_valid = 1; inv_vaddr = VA_R | (48'd5 << 12);
        tick();
        do_fill(48'h3000_0000_0000, 28'h0000E00, 2'd0, 3'b001);
        look(VA_R | 48'h1000, 2'd0, 1, 40'h0000002000, "R6 free slot preferred");
        look(48'h3000_0000_0000, 2'd0, 1, 40'h0000E00000, "R6 free slot filled");
        do_fill(48'h4000_0000_0000, 28'h0000D00, 2'd0, 3'b001);
        look(VA_R | 48'h1000, 2'd0, 0, '0, "R6 pointer moved to slot 1");
        look(VA_R | 48'h2000, 2'd0, 1, 40'h0000003000, "R6 slot 2 kept");

        repeat (2) @(posedge clk);
        #3;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule